// File: doc/BRIEF.md
# Latched Fault Status Register

This block holds one byte of device-specific status for a power-management serial bus target. Condition lines from the controller and from the power stage feed it directly. Four fault and warning bits are sticky. They set when their condition is seen and stay set until software writes a one to that bit position. Two bits follow their conditions live: the power-stage drive-supply undervoltage and the pulse-catcher summary. An informational conduction-mode bit is also live. One bit position is reserved.

A protocol engine outside this block issues single-cycle read and write strobes. A read strobe returns the byte one cycle later, marked by a valid pulse. A write strobe applies its data byte as a clear mask. Two outputs are driven from the fault and warning bits: an alert request and a summary flag for the global status word. The informational mode bit drives neither of them.

Top module: `mfr_status_reg`

## Requirements
- R1: After synchronous reset, every sticky bit is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: The sticky bits are bit 6 (controller bandgap overtemperature), bit 5 (power-stage fault), bit 4 (power-stage communications warning) and bit 1 (power-stage overtemperature). Each one sets at the clock edge on which its condition input is high, and stays set after the condition drops.
- R3: A write with a 1 at a sticky bit position clears that bit at the write's clock edge. A 0 at any position leaves that bit unchanged.
- R4: When a clear of a sticky bit and a detection of its condition fall on the same edge, the bit stays set.
- R5: Bit 7 reads the level of `cond_mode` at the read edge. Writes have no effect on it.
- R6: Bit 0 reads the level of `cond_ps_uv` at the read edge. It is never latched.
- R7: Bit 3 reads as 1 whenever `pc_any` is high. A write cannot clear it, and it reads 0 only once `pc_any` is low.
- R8: Bit 2 always reads 0.
- R9: `alert_req` and `status_summary` are high exactly when any of bits 6, 5, 4, 3, 1 or 0 of the current status is 1. Bit 7 never drives them.
- R10: A read strobe at edge E puts the status held just before E on `rd_data`, with `rd_valid` high for one cycle after E. A write in the same cycle as the read does not affect the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_mode | input | 1 | Discontinuous-conduction mode indicator (informational) |
| cond_bg_ot | input | 1 | Controller bandgap overtemperature detected |
| cond_ps_fault | input | 1 | Power-stage fault detected |
| cond_ps_comm | input | 1 | Power-stage communications error detected |
| pc_any | input | 1 | Any bit set in the pulse-catcher status register |
| cond_ps_ot | input | 1 | Power-stage overtemperature detected |
| cond_ps_uv | input | 1 | Power-stage drive-supply undervoltage |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, used as a clear mask |
| rd_data | output | 8 | Returned status byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| alert_req | output | 1 | Alert request |
| status_summary | output | 1 | Contribution to the global status word |

## Verification
The hardest case to reach from the ports is a single edge on which a clear of a sticky bit and a fresh detection of the same bit coincide. The stimulus reaches it by holding the condition high during the write cycle, then dropping the condition and reading back. A second awkward case is a read and a clear in the same cycle: the returned byte must show the state before the clear, and a later read must show the state after it. The bench also writes ones into the live and read-only positions while their inputs are high. This shows through reads that those writes cannot remove the bits.

// File: rtl/mfr_status_pkg.sv
package mfr_status_pkg;

    localparam int REG_W = 8;

    // Bit positions (ordering is visible to software)
    localparam int POS_MODE  = 7;
    localparam int POS_BGOT  = 6;
    localparam int POS_PSF   = 5;
    localparam int POS_COMM  = 4;
    localparam int POS_PC    = 3;
    localparam int POS_RSVD  = 2;
    localparam int POS_PSOT  = 1;
    localparam int POS_UV    = 0;

    localparam logic [REG_W-1:0] STICKY_MASK =
        REG_W'((1 << POS_BGOT) | (1 << POS_PSF) | (1 << POS_COMM) | (1 << POS_PSOT));
    localparam logic [REG_W-1:0] LIVE_MASK =
        REG_W'((1 << POS_MODE) | (1 << POS_PC) | (1 << POS_UV));
    localparam logic [REG_W-1:0] INFO_MASK = REG_W'(1 << POS_MODE);
    localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1 << POS_RSVD);
    localparam logic [REG_W-1:0] FAULT_MASK = (STICKY_MASK | LIVE_MASK) & ~INFO_MASK & ~RSVD_MASK;

    typedef struct packed {
        logic mode;
        logic bg_ot;
        logic ps_fault;
        logic ps_comm;
        logic pc_any;
        logic ps_ot;
        logic ps_uv;
    } cond_t;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rd_resp_t;

    function automatic logic [REG_W-1:0] place_conditions(input cond_t c);
        logic [REG_W-1:0] v;
        v           = '0;
        v[POS_MODE] = c.mode;
        v[POS_BGOT] = c.bg_ot;
        v[POS_PSF]  = c.ps_fault;
        v[POS_COMM] = c.ps_comm;
        v[POS_PC]   = c.pc_any;
        v[POS_PSOT] = c.ps_ot;
        v[POS_UV]   = c.ps_uv;
        return v;
    endfunction

endpackage

// File: rtl/mfr_sticky_bit.sv
module mfr_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic detect,
    input  logic clear,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (detect)  q <= 1'b1;   // detection wins over clear
        else if (clear)   q <= 1'b0;
    end
endmodule

// File: rtl/mfr_status_view.sv
module mfr_status_view
    import mfr_status_pkg::*;
(
    input  logic [REG_W-1:0] latched_q,
    input  logic [REG_W-1:0] ev_vec,
    output logic [REG_W-1:0] view,
    output logic             any_fault
);
    always_comb begin
        view      = ((latched_q & STICKY_MASK) | (ev_vec & LIVE_MASK)) & ~RSVD_MASK;
        any_fault = |(view & FAULT_MASK);
    end
endmodule

// File: rtl/mfr_read_port.sv
module mfr_read_port
    import mfr_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [REG_W-1:0] view,
    output rd_resp_t         resp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.valid <= rd_en;
            if (rd_en) resp.data <= view;
        end
    end
endmodule

// File: rtl/mfr_status_reg.sv
module mfr_status_reg
    import mfr_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond_mode,
    input  logic       cond_bg_ot,
    input  logic       cond_ps_fault,
    input  logic       cond_ps_comm,
    input  logic       pc_any,
    input  logic       cond_ps_ot,
    input  logic       cond_ps_uv,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       alert_req,
    output logic       status_summary
);
    cond_t            conds;
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] latched_q;
    logic [REG_W-1:0] view;
    logic             any_fault;
    rd_resp_t         resp;

    always_comb begin
        conds = '{mode: cond_mode, bg_ot: cond_bg_ot, ps_fault: cond_ps_fault,
                  ps_comm: cond_ps_comm, pc_any: pc_any, ps_ot: cond_ps_ot,
                  ps_uv: cond_ps_uv};
        ev_vec  = place_conditions(conds);
        clr_vec = wr_en ? (wr_data & STICKY_MASK) : '0;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            mfr_sticky_bit u_cell (
                .clk    (clk),
                .rst    (rst),
                .detect (ev_vec[i]),
                .clear  (clr_vec[i]),
                .q      (latched_q[i])
            );
        end else begin : g_none
            assign latched_q[i] = 1'b0;
        end
    end

    mfr_status_view u_view (
        .latched_q (latched_q),
        .ev_vec    (ev_vec),
        .view      (view),
        .any_fault (any_fault)
    );

    mfr_read_port u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .view  (view),
        .resp  (resp)
    );

    assign rd_data        = resp.data;
    assign rd_valid       = resp.valid;
    assign alert_req      = any_fault;
    assign status_summary = any_fault;
endmodule

// File: rtl/mfr_status_reg_chk.sv
module mfr_status_reg_chk
    import mfr_status_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [REG_W-1:0] ev_vec,
    input logic [REG_W-1:0] latched_q,
    input logic [7:0]       rd_data,
    input logic             rd_valid,
    input logic             alert_req,
    input logic             status_summary
);
    AST_STICKY_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched_q & $past(ev_vec & STICKY_MASK)) == $past(ev_vec & STICKY_MASK))); // R2

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((latched_q & $past(latched_q)) == $past(latched_q))); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[POS_RSVD] == 1'b0)); // R8

    AST_MODE_NO_ALERT: assert property (@(posedge clk) disable iff (rst)
        (latched_q == '0 && (ev_vec & ~INFO_MASK) == '0) |-> !alert_req); // R9

    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
        alert_req == status_summary); // R9

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R10

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R10
endmodule

bind mfr_status_reg mfr_status_reg_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .ev_vec         (ev_vec),
    .latched_q      (latched_q),
    .rd_data        (rd_data),
    .rd_valid       (rd_valid),
    .alert_req      (alert_req),
    .status_summary (status_summary)
);

// File: tb/mfr_status_reg_test.sv
module mfr_status_reg_test;
    localparam logic [7:0] STICKY = 8'h72;
    localparam logic [7:0] LIVE   = 8'h89;
    localparam logic [7:0] FAULTS = 8'h7B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cond_mode = 0, cond_bg_ot = 0, cond_ps_fault = 0, cond_ps_comm = 0;
    logic pc_any = 0, cond_ps_ot = 0, cond_ps_uv = 0;
    logic rd_en = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic rd_valid, alert_req, status_summary;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] ref_sticky = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    mfr_status_reg uut (
        .clk(clk), .rst(rst), .cond_mode(cond_mode), .cond_bg_ot(cond_bg_ot),
        .cond_ps_fault(cond_ps_fault), .cond_ps_comm(cond_ps_comm), .pc_any(pc_any),
        .cond_ps_ot(cond_ps_ot), .cond_ps_uv(cond_ps_uv), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .alert_req(alert_req), .status_summary(status_summary)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: ev uses the status bit positions as its layout.
    task automatic drive(input string tag, input logic [7:0] ev, input logic wr,
                         input logic [7:0] wd, input logic rd);
        logic [7:0] live_view;
        logic       exp_alert;
        @(negedge clk);
        cond_mode = ev[7]; cond_bg_ot = ev[6]; cond_ps_fault = ev[5]; cond_ps_comm = ev[4];
        pc_any = ev[3]; cond_ps_ot = ev[1]; cond_ps_uv = ev[0];
        wr_en = wr; wr_data = wd; rd_en = rd;
        live_view = (ref_sticky & STICKY) | (ev & LIVE);
        exp_alert = |(live_view & FAULTS);
        #1;
        check({tag, " alert"},   {7'd0, alert_req},      {7'd0, exp_alert});
        check({tag, " summary"}, {7'd0, status_summary}, {7'd0, exp_alert});
        if (rd) begin
            exp_q.push_back(live_view);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        ref_sticky = ((ref_sticky & ~(wr ? wd : 8'h00)) | ev) & STICKY;
    endtask

    // Monitor: compares each returned byte against the queued expectation
    always @(posedge clk) begin
        #2;
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected valid", 8'h01, 8'h00);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 rd_data after reset",  rd_data, 8'h00);
        check("R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
        drive("R1 read after reset", 8'h00, 0, 8'h00, 1);

        drive("R2 bandgap pulse",        8'h40, 0, 8'h00, 0);
        drive("R2 bandgap stays set",    8'h00, 0, 8'h00, 1);
        drive("R2 psf pulse",            8'h20, 0, 8'h00, 0);
        drive("R2 comm+ot pulse",        8'h12, 0, 8'h00, 0);
        drive("R2 all sticky held",      8'h00, 0, 8'h00, 1);

        drive("R3 write zeros",          8'h00, 1, 8'h00, 0);
        drive("R3 zeros no effect",      8'h00, 0, 8'h00, 1);
        drive("R3 clear psf",            8'h00, 1, 8'h20, 0);
        drive("R3 psf cleared",          8'h00, 0, 8'h00, 1);

        drive("R4 clear vs detect",      8'h40, 1, 8'h40, 0);
        drive("R4 detect wins",          8'h00, 0, 8'h00, 1);

        drive("R3 clear all",            8'h00, 1, 8'hFF, 0);
        drive("R3 all cleared",          8'h00, 0, 8'h00, 1);

        drive("R5 R9 mode live no alert", 8'h80, 0, 8'h00, 1);
        drive("R5 write mode bit",        8'h80, 1, 8'h80, 0);
        drive("R5 mode unaffected",       8'h80, 0, 8'h00, 1);
        drive("R5 mode dropped",          8'h00, 0, 8'h00, 1);

        drive("R6 uv live",              8'h01, 0, 8'h00, 1);
        drive("R6 uv not latched",       8'h00, 0, 8'h00, 1);

        drive("R7 pc write ignored",     8'h08, 1, 8'h08, 0);
        drive("R7 pc still set",         8'h08, 0, 8'h00, 1);
        drive("R7 pc clears with source", 8'h00, 0, 8'h00, 1);

        drive("R8 write reserved",       8'h00, 1, 8'h04, 0);
        drive("R8 all conditions",       8'hFB, 0, 8'h00, 1);
        drive("R8 R9 sticky after drop", 8'h00, 0, 8'h00, 1);

        drive("R10 read with clear",     8'h00, 1, 8'hFF, 1);
        drive("R10 read after clear",    8'h00, 0, 8'h00, 1);
        drive("R9 idle",                 8'h00, 0, 8'h00, 0);
        drive("R9 idle",                 8'h00, 0, 8'h00, 0);

        check("R10 all reads returned", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule